// File: doc/BRIEF.md
# Zero-Suppressing Channel Scanner with Event Buffer

This block sequences the conversion of 64 analog channels on its own once a trigger arrives. It steps the multiplexer select from channel 0 to channel 63. For each channel it pulses the converter start and waits for the converter's done strobe. A sample is kept only when it is strictly greater than a programmable threshold. A kept sample is written to a 64-word buffer together with its 6-bit channel number.

Each event is released for readout only when all of its conversions are finished. The buffer can hold two events at once. A new event can therefore be scanned while the previous one is still shifting out. The readout side sees an empty flag and clocks words out one bit per cycle with a shift enable. Each word carries an end-of-event bit, so the reader can tell where one event stops and the next begins. The multiplexer and the converter are outside this block.

Top module: `zs_scanner`

## Requirements
- R1: After reset, `adc_start_o` is 0, `mux_sel_o` is 0, `empty_o` is 1 and `ser_o` is 0.
- R2: A trigger accepted while idle scans channels 0 to 63 in ascending order. Each channel gets exactly one single-cycle `adc_start_o` pulse. The next pulse comes only after `adc_done_i` for the current channel, and `mux_sel_o` holds the channel number until that done strobe.
- R3: A sample is stored only when `adc_data_i` is strictly greater than `thresh_i`. A sample equal to or below the threshold is discarded.
- R4: Each word is 15 bits and leaves MSB first on `ser_o`. Bit 14 is the end-of-event flag, bits 13:8 are the channel number and bits 7:0 are the sample. One bit advances on each cycle with `shift_i` high while `empty_o` is 0.
- R5: Within an event, only the last stored word has the end-of-event flag set to 1.
- R6: `empty_o` stays 1 until the scan of an event with at least one stored sample is complete. An event with no stored sample never clears `empty_o`.
- R7: A trigger is ignored while a scan is running. It is also ignored while two completed events are waiting in the buffer.
- R8: A trigger is accepted while one earlier event is still being read out. Events are read out in the order they were scanned.
- R9: The buffer holds 64 words. An above-threshold sample that arrives while the buffer is full is dropped, and the end-of-event flag goes on that event's last stored word.
- R10: While `empty_o` is 1, `ser_o` is 0 and `shift_i` has no effect. The next word still starts at bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Event trigger |
| thresh_i | input | 8 | Zero-suppression threshold |
| adc_done_i | input | 1 | Converter result valid strobe |
| adc_data_i | input | 8 | Converter result |
| shift_i | input | 1 | Serial readout shift enable |
| mux_sel_o | output | 6 | Multiplexer channel select |
| adc_start_o | output | 1 | Converter start pulse |
| empty_o | output | 1 | No completed event available |
| ser_o | output | 1 | Serial readout data |

## Verification
The hardest state to reach is a buffer that fills while an event is being scanned. Getting there needs one complete event still waiting, plus a second event whose hits go past the remaining space. The bench leaves a 39-word event unread and then scans a second 39-hit event. Only 25 of the second event's words fit, so the end-of-event flag must land on channel 49. A second hard case is readout running at the same time as a scan. The bench forks a drain of a short event against a fresh scan and confirms that `empty_o` stays high until that scan completes.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_FIN
  } scan_st_e;
endpackage

// File: rtl/zs_seq.sv
module zs_seq
  import zs_pkg::*;
#(
  parameter int N_CH  = 64,
  parameter int SMP_W = 8,
  localparam int CH_W = $clog2(N_CH),
  localparam int DW   = CH_W + SMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [SMP_W-1:0] thresh_i,
  input  logic             adc_done_i,
  input  logic [SMP_W-1:0] adc_data_i,
  input  logic             bank_free_i,
  input  logic             full_i,
  output logic [CH_W-1:0]  mux_sel_o,
  output logic             adc_start_o,
  output logic             wr_en_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             close_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

  scan_st_e        st_q;
  logic [CH_W-1:0] ch_q;
  logic            hit_q;
  logic            keep;

  assign keep = (st_q == ST_WAIT) && adc_done_i && (adc_data_i > thresh_i) && !full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ch_q  <= '0;
      hit_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (trig_i && bank_free_i) begin
          st_q  <= ST_START;
          ch_q  <= '0;
          hit_q <= 1'b0;
        end
        ST_START: st_q <= ST_WAIT;
        ST_WAIT: if (adc_done_i) begin
          if (keep) hit_q <= 1'b1;
          if (ch_q == LAST_CH) st_q <= ST_FIN;
          else begin
            ch_q <= ch_q + 1'b1;
            st_q <= ST_START;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign adc_start_o = (st_q == ST_START);
  assign mux_sel_o   = ch_q;
  assign wr_en_o     = keep;
  assign wr_data_o   = {ch_q, adc_data_i};
  assign close_o     = (st_q == ST_FIN) && hit_q;

  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);
  // R2
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !adc_done_i) |=> $stable(mux_sel_o));
endmodule

// File: rtl/zs_fifo.sv
module zs_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 14,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          close_i,
  input  logic          pop_i,
  output logic          full_o,
  output logic [DW:0]   rd_data_o,
  output logic [1:0]    done_cnt_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] eoe_q;
  logic [AW-1:0]    wp_q, rp_q, last_wp;
  logic [CW-1:0]    cnt_q;
  logic [1:0]       done_q;
  logic             pop_eoe;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign last_wp   = (wp_q == '0) ? AW'(DEPTH - 1) : wp_q - 1'b1;
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign rd_data_o = {eoe_q[rp_q], mem_q[rp_q]};
  assign pop_eoe   = pop_i && eoe_q[rp_q];
  assign done_cnt_o = done_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      eoe_q  <= '0;
      done_q <= '0;
    end else begin
      if (wr_en_i) begin
        eoe_q[wp_q] <= 1'b0;
        wp_q        <= nxt(wp_q);
      end
      if (close_i) eoe_q[last_wp] <= 1'b1;
      if (pop_i) rp_q <= nxt(rp_q);
      case ({wr_en_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
      case ({close_i, pop_eoe})
        2'b10:   done_q <= done_q + 1'b1;
        2'b01:   done_q <= done_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_o);
  // R7
  bank_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q <= 2'd2);
  // R6
  pop_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> done_q != 2'd0);
  // R5
  close_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |-> cnt_q != '0);
endmodule

// File: rtl/zs_ser.sv
module zs_ser #(
  parameter int W   = 15,
  localparam int BW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ready_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         pop_o,
  output logic         ser_o
);
  logic [BW-1:0] bit_q;
  logic          last;

  assign last  = (bit_q == BW'(W - 1));
  assign pop_o = shift_i && ready_i && last;
  assign ser_o = ready_i && word_i[BW'(W - 1) - bit_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= '0;
    else if (shift_i && ready_i) bit_q <= last ? '0 : bit_q + 1'b1;
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(bit_q));
endmodule

// File: rtl/zs_scanner.sv
module zs_scanner #(
  parameter int N_CH  = 64,
  parameter int SMP_W = 8,
  parameter int DEPTH = 64,
  localparam int CH_W = $clog2(N_CH),
  localparam int DW   = CH_W + SMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [SMP_W-1:0] thresh_i,
  input  logic             adc_done_i,
  input  logic [SMP_W-1:0] adc_data_i,
  input  logic             shift_i,
  output logic [CH_W-1:0]  mux_sel_o,
  output logic             adc_start_o,
  output logic             empty_o,
  output logic             ser_o
);
  logic          wr_en, close, pop, full;
  logic [DW-1:0] wr_data;
  logic [DW:0]   rd_data;
  logic [1:0]    done_cnt;

  assign empty_o = (done_cnt == 2'd0);

  zs_seq #(.N_CH(N_CH), .SMP_W(SMP_W)) u_seq (
    .clk_i, .rst_ni, .trig_i, .thresh_i, .adc_done_i, .adc_data_i,
    .bank_free_i(done_cnt < 2'd2),
    .full_i     (full),
    .mux_sel_o,
    .adc_start_o,
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .close_o    (close)
  );

  zs_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .close_i   (close),
    .pop_i     (pop),
    .full_o    (full),
    .rd_data_o (rd_data),
    .done_cnt_o(done_cnt)
  );

  zs_ser #(.W(DW + 1)) u_ser (
    .clk_i, .rst_ni,
    .ready_i(!empty_o),
    .word_i (rd_data),
    .shift_i,
    .pop_o  (pop),
    .ser_o
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> empty_o && !adc_start_o);
endmodule

// File: tb/zs_scanner_tb_top.sv
module zs_scanner_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       trig_i = 1'b0, adc_done_i = 1'b0, shift_i = 1'b0;
  logic [7:0] thresh_i = '0, adc_data_i = '0;
  logic [5:0] mux_sel_o;
  logic       adc_start_o, empty_o, ser_o;

  int n_chk = 0, n_fail = 0;
  int n_starts = 0, seq_err = 0, cur_pat = 0;

  // {pattern[16:15], threshold[14:7], expected stored count[6:0]}
  localparam logic [16:0] VEC [7] = '{
    {2'd0, 8'd99,  7'd39},
    {2'd1, 8'd0,   7'd64},
    {2'd2, 8'd128, 7'd32},
    {2'd2, 8'd10,  7'd32},
    {2'd3, 8'd128, 7'd2},
    {2'd0, 8'd255, 7'd0},
    {2'd1, 8'd127, 7'd32}
  };

  zs_scanner dut_i (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic logic [7:0] pat_val(input int p, input int ch);
    case (p)
      0:       return 8'(ch * 4 + 3);
      1:       return 8'(255 - ch * 4);
      2:       return ch[0] ? 8'd10 : 8'd200;
      default: return (ch == 5 || ch == 63) ? 8'h81 : 8'h80;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  initial forever begin
    @(negedge clk_i);
    adc_done_i = 1'b0;
    if (adc_start_o) begin
      if (mux_sel_o != 6'(n_starts)) seq_err++;
      n_starts++;
      @(negedge clk_i);
      adc_data_i = pat_val(cur_pat, int'(mux_sel_o));
      adc_done_i = 1'b1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic run_event(input int p, input int th, input bit retrig, input bit exp_empty_mid);
    bit done_rt = 1'b0;
    seq_err = 0; n_starts = 0; cur_pat = p; thresh_i = 8'(th);
    @(negedge clk_i) trig_i = 1'b1;
    @(negedge clk_i) trig_i = 1'b0;
    while (n_starts < 64) begin
      @(negedge clk_i);
      if (retrig && !done_rt && n_starts == 10) begin
        done_rt = 1'b1;
        trig_i = 1'b1;
        @(negedge clk_i) trig_i = 1'b0;
      end
    end
    chk(empty_o == exp_empty_mid, "R6 empty during scan", empty_o, exp_empty_mid);
    repeat (12) @(negedge clk_i);
    chk(n_starts == 64, "R2/R7 start count", n_starts, 64);
    chk(seq_err == 0, "R2 channel order", seq_err, 0);
  endtask

  task automatic read_word(output logic [14:0] w);
    w = '0;
    for (int b = 0; b < 15; b++) begin
      @(negedge clk_i);
      w = {w[13:0], ser_o};
      shift_i = 1'b1;
    end
    @(negedge clk_i) shift_i = 1'b0;
  endtask

  task automatic read_event(input int p, input int th, input int cap, input int exp_n,
                            input bit exp_empty_after);
    int n = 0, k = 0;
    logic [14:0] w, e;
    for (int ch = 0; ch < 64; ch++) if (pat_val(p, ch) > 8'(th) && n < cap) n++;
    for (int ch = 0; ch < 64; ch++) begin
      if (pat_val(p, ch) > 8'(th) && k < n) begin
        if (empty_o) begin
          chk(1'b0, "R3 word missing", k, n);
          break;
        end
        read_word(w);
        e = {k == n - 1, 6'(ch), pat_val(p, ch)};
        chk(w == e, "R3/R4/R5/R9 word", w, e);
        k++;
      end
    end
    chk(k == exp_n, "R3/R9 stored count", k, exp_n);
    chk(empty_o == exp_empty_after, "R5/R6 empty after event", empty_o, exp_empty_after);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk(adc_start_o == 0 && mux_sel_o == 0, "R1 reset outputs", {adc_start_o, mux_sel_o}, 0);
    chk(empty_o == 1 && ser_o == 0, "R1 reset readout", {empty_o, ser_o}, 2);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // table: one event at a time; entry 0 also retriggers mid-scan (R7)
    foreach (VEC[i]) begin
      run_event(int'(VEC[i][16:15]), int'(VEC[i][14:7]), i == 0, 1'b1);
      if (VEC[i][6:0] == 0)
        chk(empty_o == 1, "R6 no-hit event stays empty", empty_o, 1);
      else
        read_event(int'(VEC[i][16:15]), int'(VEC[i][14:7]), 64, int'(VEC[i][6:0]), 1'b1);
    end

    // R7: two completed events refuse a third trigger; R8: order kept
    run_event(3, 128, 1'b0, 1'b1);
    run_event(2, 199, 1'b0, 1'b0);
    n_starts = 0;
    @(negedge clk_i) trig_i = 1'b1;
    @(negedge clk_i) trig_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk(n_starts == 0, "R7 trigger refused when banks full", n_starts, 0);
    read_event(3, 128, 64, 2, 1'b0);
    read_event(2, 199, 64, 32, 1'b1);

    // R8: scan a new event while the previous drains
    run_event(3, 128, 1'b0, 1'b1);
    fork
      run_event(0, 99, 1'b0, 1'b1);
      begin
        repeat (3) @(negedge clk_i);
        read_event(3, 128, 64, 2, 1'b1);
      end
    join
    read_event(0, 99, 64, 39, 1'b1);

    // R9: second event overflows the buffer, 25 words fit
    run_event(0, 99, 1'b0, 1'b1);
    run_event(0, 99, 1'b0, 1'b0);
    read_event(0, 99, 64, 39, 1'b0);
    read_event(0, 99, 25, 25, 1'b1);

    // R10: shifting while empty does nothing
    shift_i = 1'b1;
    repeat (7) begin
      @(negedge clk_i);
      chk(ser_o == 0 && empty_o == 1, "R10 quiet while empty", {empty_o, ser_o}, 2);
    end
    shift_i = 1'b0;
    run_event(3, 128, 1'b0, 1'b1);
    read_event(3, 128, 64, 2, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule